// File: doc/BRIEF.md
# BCD Calendar Counter with Coherent Snapshot

This block keeps a running calendar (seconds, minutes, hours, day of month, month, two-digit year and a weekday index) in packed BCD. It advances once per pulse on a one-per-second tick input that is synchronous to the system clock. Software reaches it through an 8-bit register port made of an address, a write strobe, write data and a combinational read-data output.

Software sets the time by clearing the run bit, writing the fields one at a time and setting the run bit again. A time read spread over several register accesses could straddle a carry and return, for example, the old minute with the new second. To avoid this, software raises a snapshot bit. That copies every live field into a shadow set in a single clock. A second control bit then points reads of the time offsets at the shadow copy, so the whole multi-byte read describes one instant.

Top module: `bcd_calendar_rtc`

## Requirements
- R1: Offsets 0..6 hold, in order, seconds, minutes, hours, day, month, year and weekday. The control register sits at offset 8 and the status register at offset 9. Every other offset reads 0x00.
- R2: After reset the counter is stopped, control and status read 0x00, day and month read 0x01, and all other time fields read 0x00.
- R3: The fields advance on a tick only while control bit 0 is 1. With bit 0 at 0, ticks are ignored and every field holds its value.
- R4: Each counted tick adds one second. Seconds roll 59→00 and carry into minutes, minutes roll 59→00 and carry into hours, and hours roll 23→00 and carry into the day.
- R5: The day rolls to 01 after the last day of the month: 30 for months 04, 06, 09 and 11, 29 for February in a year divisible by 4, 28 for February otherwise, and 31 for the rest. Each day carry moves the weekday on, and weekday 06 wraps to 00. Month 12 rolls to 01 and carries into the year, and year 99 wraps to 00.
- R6: While stopped, a write to offsets 0..6 loads that field with the write data at the clock edge. While running, such writes are ignored.
- R7: A control write that changes bit 6 from 0 to 1 copies all seven live fields into the shadow set. If a tick lands in the same cycle, the copy holds the values from before that tick. Writing bit 6 as 1 while it already reads 1 takes no new copy.
- R8: With control bit 7 at 1, offsets 0..6 return the shadow copy. With bit 7 at 0, they return the live fields.
- R9: Control reads back bits 7, 6, 3 and 0 as written, with all other bits 0. Status bit 1 reads 1 exactly while the counter runs, and the other status bits read 0.
- R10: Control bit 3 is stored but has no effect: hours always count 00..23.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| reg_addr | input | 4 | Register offset |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |

## Verification
The collision that matters is a snapshot request arriving in the same clock as a counting tick, since both touch the time fields at one edge. The bench provokes it by raising the tick together with the control write that sets bit 6, at moments when the seconds sit at 59 so that the tick causes a carry. It then reads the shadow set, which must match the time before the tick, and the live set, which must match the time after it. Random runs that load times close to rollovers check the carry chain against a bench model of the calendar.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int NUM_FIELDS = 7;
  localparam int FW         = 8;
  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DAY  = 3;
  localparam int F_MON  = 4;
  localparam int F_YEAR = 5;
  localparam int F_WDAY = 6;

  localparam int CB_RUN  = 0;
  localparam int CB_H12  = 3;
  localparam int CB_SNAP = 6;
  localparam int CB_SHRD = 7;
  localparam logic [FW-1:0] CTRL_MASK = 8'hC9;
  localparam int SB_RUN = 1;

  typedef logic [NUM_FIELDS-1:0][FW-1:0] cal_time_t;

  localparam cal_time_t TIME_RST = '{8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

  function automatic logic [FW-1:0] bcd_inc(input logic [FW-1:0] v);
    if (v[3:0] >= 4'd9) bcd_inc = {v[7:4] + 4'd1, 4'd0};
    else                bcd_inc = {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic leap_bcd(input logic [FW-1:0] y);
    if (y[4]) leap_bcd = (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    else      leap_bcd = (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic logic [FW-1:0] month_last(input logic [FW-1:0] mo, input logic [FW-1:0] y);
    case (mo)
      8'h02:                      month_last = leap_bcd(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: month_last = 8'h30;
      default:                    month_last = 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/cal_time_core.sv
module cal_time_core
  import cal_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_i,
  input  logic                  run_i,
  input  logic [NUM_FIELDS-1:0] ld_en_i,
  input  logic [FW-1:0]         ld_data_i,
  output cal_time_t             live_o
);
  cal_time_t cur_q, nxt;
  logic adv, c_min, c_hour, c_day, c_mon, c_year, upd_en;

  always_comb begin
    nxt    = cur_q;
    adv    = tick_i & run_i;
    c_min  = adv    && (cur_q[F_SEC]  >= 8'h59);
    c_hour = c_min  && (cur_q[F_MIN]  >= 8'h59);
    c_day  = c_hour && (cur_q[F_HOUR] >= 8'h23);
    c_mon  = c_day  && (cur_q[F_DAY]  >= month_last(cur_q[F_MON], cur_q[F_YEAR]));
    c_year = c_mon  && (cur_q[F_MON]  >= 8'h12);
    if (adv) begin
      nxt[F_SEC] = c_min ? 8'h00 : bcd_inc(cur_q[F_SEC]);
      if (c_min)  nxt[F_MIN]  = c_hour ? 8'h00 : bcd_inc(cur_q[F_MIN]);
      if (c_hour) nxt[F_HOUR] = c_day  ? 8'h00 : bcd_inc(cur_q[F_HOUR]);
      if (c_day) begin
        nxt[F_DAY]  = c_mon ? 8'h01 : bcd_inc(cur_q[F_DAY]);
        nxt[F_WDAY] = (cur_q[F_WDAY] >= 8'h06) ? 8'h00 : bcd_inc(cur_q[F_WDAY]);
      end
      if (c_mon)  nxt[F_MON]  = c_year ? 8'h01 : bcd_inc(cur_q[F_MON]);
      if (c_year) nxt[F_YEAR] = (cur_q[F_YEAR] >= 8'h99) ? 8'h00 : bcd_inc(cur_q[F_YEAR]);
    end else if (!run_i) begin
      for (int i = 0; i < NUM_FIELDS; i++)
        if (ld_en_i[i]) nxt[i] = ld_data_i;
    end
    upd_en = adv | ((|ld_en_i) & ~run_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur_q <= TIME_RST;
    else if (upd_en) cur_q <= nxt;
  end

  assign live_o = cur_q;

  p_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && ld_en_i == '0) |=> $stable(cur_q));
  p_run_ignores_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !tick_i) |=> $stable(cur_q));
  p_sec_roll_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && run_i && cur_q[F_SEC] == 8'h59) |=> (cur_q[F_SEC] == 8'h00));
  p_hour_roll_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && run_i && cur_q[F_HOUR] == 8'h23 && cur_q[F_MIN] == 8'h59 && cur_q[F_SEC] == 8'h59)
    |=> (cur_q[F_HOUR] == 8'h00));
  p_new_year_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && run_i && cur_q[F_MON] == 8'h12 && cur_q[F_DAY] == 8'h31 &&
     cur_q[F_HOUR] == 8'h23 && cur_q[F_MIN] == 8'h59 && cur_q[F_SEC] == 8'h59)
    |=> (cur_q[F_MON] == 8'h01 && cur_q[F_DAY] == 8'h01));
endmodule

// File: rtl/cal_snapshot.sv
module cal_snapshot
  import cal_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      snap_i,
  input  cal_time_t live_i,
  output cal_time_t shadow_o
);
  cal_time_t shd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      shd_q <= TIME_RST;
    else if (snap_i) shd_q <= live_i;
  end

  assign shadow_o = shd_q;

  p_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
    snap_i |=> (shd_q == $past(live_i)));
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_i |=> $stable(shd_q));
endmodule

// File: rtl/cal_regs.sv
module cal_regs
  import cal_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int CTRL_ADDR = 8,
  parameter int STAT_ADDR = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic                  we_i,
  input  logic [FW-1:0]         wdata_i,
  input  cal_time_t             live_i,
  input  cal_time_t             shadow_i,
  output logic                  run_o,
  output logic                  snap_o,
  output logic [NUM_FIELDS-1:0] ld_en_o,
  output logic [FW-1:0]         rdata_o
);
  logic [FW-1:0] ctrl_q, ctrl_nxt;
  logic          ctrl_wr, is_time;
  cal_time_t     src;

  always_comb begin
    ctrl_wr  = we_i && (addr_i == ADDR_W'(CTRL_ADDR));
    ctrl_nxt = wdata_i & CTRL_MASK;
    snap_o   = ctrl_wr && wdata_i[CB_SNAP] && !ctrl_q[CB_SNAP];
  end

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_ld
    assign ld_en_o[g] = we_i && (addr_i == ADDR_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= ctrl_nxt;
  end

  assign run_o = ctrl_q[CB_RUN];

  always_comb begin
    src     = ctrl_q[CB_SHRD] ? shadow_i : live_i;
    is_time = (addr_i < ADDR_W'(NUM_FIELDS));
    rdata_o = '0;
    if (is_time)                           rdata_o = src[addr_i[$clog2(NUM_FIELDS)-1:0]];
    else if (addr_i == ADDR_W'(CTRL_ADDR)) rdata_o = ctrl_q;
    else if (addr_i == ADDR_W'(STAT_ADDR)) rdata_o[SB_RUN] = ctrl_q[CB_RUN];
  end

  p_ctrl_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (ctrl_q == ($past(wdata_i) & CTRL_MASK)));
  p_ctrl_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(ctrl_q));
  p_no_resnap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[CB_SNAP] |-> !snap_o);
endmodule

// File: rtl/bcd_calendar_rtc.sv
module bcd_calendar_rtc
  import cal_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int CTRL_ADDR = 8,
  parameter int STAT_ADDR = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata
);
  logic [1:0]            rst_sync_q;
  logic                  rst_int_n;
  logic                  run, snap;
  logic [NUM_FIELDS-1:0] ld_en;
  cal_time_t             live, shadow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  cal_regs #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .addr_i(reg_addr), .we_i(reg_we), .wdata_i(reg_wdata),
    .live_i(live), .shadow_i(shadow), .run_o(run), .snap_o(snap), .ld_en_o(ld_en),
    .rdata_o(reg_rdata));

  cal_time_core u_core (
    .clk(clk), .rst_n(rst_int_n), .tick_i(tick_1hz), .run_i(run), .ld_en_i(ld_en),
    .ld_data_i(reg_wdata), .live_o(live));

  cal_snapshot u_snap (
    .clk(clk), .rst_n(rst_int_n), .snap_i(snap), .live_i(live), .shadow_o(shadow));
endmodule

// File: tb/test_bcd_calendar_rtc.sv
module test_bcd_calendar_rtc;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_1hz = 1'b0;
  logic [3:0] reg_addr = '0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int md[7];
  int sn[7];
  logic [7:0] ctl = 8'h00;
  logic [7:0] rv;

  always #2.5 clk = ~clk;

  bcd_calendar_rtc i_bcd_calendar_rtc (.clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int mdays(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic model_tick();
    md[0]++;
    if (md[0] == 60) begin
      md[0] = 0; md[1]++;
      if (md[1] == 60) begin
        md[1] = 0; md[2]++;
        if (md[2] == 24) begin
          md[2] = 0; md[3]++; md[6] = (md[6] + 1) % 7;
          if (md[3] > mdays(md[4], md[5])) begin
            md[3] = 1; md[4]++;
            if (md[4] == 13) begin md[4] = 1; md[5] = (md[5] + 1) % 100; end
          end
        end
      end
    end
  endtask

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(input int a, output logic [7:0] v);
    @(negedge clk); reg_addr = 4'(a); #1; v = reg_rdata;
  endtask

  task automatic wr(input int a, input logic [7:0] d, input bit t);
    @(negedge clk); reg_addr = 4'(a); reg_wdata = d; reg_we = 1'b1; tick_1hz = t;
    @(negedge clk); reg_we = 1'b0; tick_1hz = 1'b0;
  endtask

  task automatic wctl(input logic [7:0] d, input bit t);
    wr(8, d, t); ctl = d & 8'hC9;
  endtask

  task automatic ticks(input int n);
    int cnt = 0;
    while (cnt < n) begin
      @(negedge clk);
      tick_1hz = ($urandom % 3) != 0;
      if (tick_1hz) begin cnt++; if (ctl[0]) model_tick(); end
    end
    @(negedge clk); tick_1hz = 1'b0;
  endtask

  task automatic cmp_all(input string req);
    for (int i = 0; i < 7; i++) begin rd(i, rv); chk(req, rv, bcd(md[i])); end
  endtask

  task automatic load(input int s, input int m, input int h, input int d, input int mo, input int y, input int w);
    wctl(ctl & 8'hFE, 1'b0);
    md[0] = s; md[1] = m; md[2] = h; md[3] = d; md[4] = mo; md[5] = y; md[6] = w;
    for (int i = 0; i < 7; i++) wr(i, bcd(md[i]), 1'b0);
    wctl(ctl | 8'h01, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    md = '{0, 0, 0, 1, 1, 0, 0};
    // R2 R1: reset values and map
    cmp_all("R2");
    rd(8, rv); chk("R2", rv, 8'h00);
    rd(9, rv); chk("R2", rv, 8'h00);
    rd(7, rv); chk("R1", rv, 8'h00);
    rd(12, rv); chk("R1", rv, 8'h00);
    // R3: stopped ignores ticks
    ticks(5); cmp_all("R3");
    // R6: load while stopped
    wr(0, 8'h42, 1'b0); md[0] = 42; rd(0, rv); chk("R6", rv, 8'h42);
    // R4 R5: leap February, carry chain
    load(58, 59, 23, 28, 2, 0, 6); ticks(3); cmp_all("R5");
    rd(9, rv); chk("R9", rv, 8'h02);
    load(59, 59, 23, 31, 12, 99, 3); ticks(1); cmp_all("R5");
    load(59, 59, 23, 28, 2, 1, 0); ticks(1); cmp_all("R5");
    load(59, 59, 23, 30, 4, 22, 2); ticks(1); cmp_all("R5");
    load(59, 59, 9, 14, 7, 50, 1); ticks(2); cmp_all("R4");
    // R6: writes while running ignored
    wr(0, 8'h33, 1'b0); wr(2, 8'h05, 1'b0); cmp_all("R6");
    // R10: bit 3 stored, hours still pass 12 and 23
    wctl(8'h09, 1'b0); rd(8, rv); chk("R10", rv, 8'h09);
    load(59, 59, 12, 5, 5, 5, 5); ticks(1); cmp_all("R10");
    load(59, 59, 23, 5, 5, 5, 5); ticks(1); cmp_all("R10");
    // R9: control readback mask and status
    wctl(8'hFF, 1'b0); rd(8, rv); chk("R9", rv, 8'hC9);
    rd(9, rv); chk("R9", rv, 8'h02);
    wctl(8'h00, 1'b0); rd(9, rv); chk("R9", rv, 8'h00);
    // R7 R8: snapshot on the same cycle as a carrying tick
    load(59, 59, 23, 31, 1, 10, 4);
    sn = md;
    wctl(8'h41, 1'b1); model_tick();
    wctl(8'hC1, 1'b0);
    for (int i = 0; i < 7; i++) begin rd(i, rv); chk("R7", rv, bcd(sn[i])); end
    ticks(7);
    for (int i = 0; i < 7; i++) begin rd(i, rv); chk("R8", rv, bcd(sn[i])); end
    wctl(8'hC1, 1'b0);
    for (int i = 0; i < 7; i++) begin rd(i, rv); chk("R7", rv, bcd(sn[i])); end
    wctl(8'h81, 1'b0); wctl(8'hC1, 1'b0); sn = md;
    ticks(3);
    for (int i = 0; i < 7; i++) begin rd(i, rv); chk("R7", rv, bcd(sn[i])); end
    wctl(8'h41, 1'b0); cmp_all("R8");
    wctl(8'h01, 1'b0);
    // random runs near rollovers
    for (int it = 0; it < 30; it++) begin
      int mo = $urandom_range(12, 1);
      int y  = $urandom_range(99, 0);
      load($urandom_range(59, 50), $urandom_range(59, 57), $urandom_range(23, 22),
           mdays(mo, y) - $urandom_range(1, 0), mo, y, $urandom_range(6, 0));
      ticks($urandom_range(300, 1));
      cmp_all("R4");
      if (it % 5 == 0) begin
        rd(0, rv);
        sn = md;
        wctl(8'h01, 1'b0);
        wctl(8'hC1, 1'b1); model_tick();
        for (int i = 0; i < 7; i++) begin rd(i, rv); chk("R7", rv, bcd(sn[i])); end
        wctl(8'h01, 1'b0);
      end
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule